// File: doc/BRIEF.md
# Masked Register Field Access Engine

This block carries out a single access instruction on one hardware register and reports the result. A caller presents an opcode, a flags byte, an address space code, a register address, a bit offset, a 64-bit stored value, a 64-bit mask and a 64-bit externally supplied write value, then pulses `start`. The engine turns the instruction into one or two transfers on a simple request/acknowledge register bus. It then returns the extracted field, a compare outcome and an error indication.

A field lies at a bit offset in the register, and the mask selects which bits of that field take part. Mask bit 0 lines up with the bit at the offset. The mask may contain holes, so a field made of register bits 6, 5, 3 and 2 is given as offset 2 with mask 0x1B. Writes either overwrite the whole register or, when the preserve flag is set, read the register first and replace only the masked bits. Reads and compares never write.

Top module: `regop_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `match`, `bus_req` are 0 and `field_out` is 0.
- R2: Opcode 0x00 (read) performs exactly one bus read and returns `field_out = (reg >> bit_off) & mask` with `match = 0`. The stored value and flags bit 0 have no effect on the result, and the register is left unchanged.
- R3: Opcode 0x01 (compare) extracts the field as in R2 and sets `match` to 1 exactly when that field equals `value`, else 0. It performs one read and no write.
- R4: Opcode 0x02 (write supplied) with flags bit 0 clear performs exactly one bus write of `(wdata_in & mask) << bit_off` and no read. Register bits outside the field become 0, and `value` has no effect. After any write, `field_out` and `match` are 0.
- R5: Opcode 0x03 (write stored) behaves as R4 but takes `value` as the source, and `wdata_in` has no effect.
- R6: With flags bit 0 (preserve) set, a write opcode performs one read followed by one write of `(old & ~(mask << bit_off)) | ((src & mask) << bit_off)`.
- R7: The mask is applied relative to the offset and may be non-contiguous. Only register bits `bit_off+i` with `mask[i] = 1` are read into the field or changed by a preserving write.
- R8: Opcode 0x04 (no-op) makes no bus access, raises `done` in the cycle after `start` with `err = 0`, and leaves the register unchanged.
- R9: An opcode above 0x04, or an address space other than 0 (memory) or 1 (I/O), makes no bus access and raises `done` in the cycle after `start` with `err = 1`.
- R10: `busy` is high from the cycle after `start` until the final acknowledge is sampled. `done` then pulses for one cycle. While `bus_req` waits for `bus_ack`, the address, direction and write data hold steady. Results stay stable until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only while idle) |
| opcode | input | 8 | Instruction code |
| flags | input | 8 | Bit 0: preserve other register bits on writes |
| addr_space | input | 8 | 0 memory, 1 I/O, others illegal |
| reg_addr | input | AW | Register address |
| bit_off | input | OFFW | Bit offset of the field |
| value | input | DW | Stored value (compare reference / write source) |
| mask | input | DW | Field mask, bit 0 at the offset |
| wdata_in | input | DW | Externally supplied write data |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data, valid with acknowledge |
| bus_ack | input | 1 | Bus acknowledge, one cycle |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| field_out | output | DW | Extracted field |
| match | output | 1 | Compare outcome |
| err | output | 1 | Illegal opcode or address space |

## Verification
The hardest case to reach is a preserving write. The merged word depends on register contents that the engine reads in the middle of the instruction, and on an acknowledge that arrives a varying number of cycles later, so the check needs known old contents together with a shifted, holed mask. The bench keeps its own register array behind a responder with latency 0 to 2 cycles. It sweeps every bit offset, with masks that have holes or run past bit 63, alternating the preserve flag for each write opcode. Each merged result is compared with the value computed from the snapshot taken before the instruction, and the number of reads and writes for that instruction is checked as well.

// File: rtl/regop_pkg.sv
// Shared codes for the register field access engine.
// Assumes byte-wide opcode and address space inputs.
package regop_pkg;
    typedef enum logic [7:0] {
        OP_READ   = 8'h00,
        OP_CHECK  = 8'h01,
        OP_WR_EXT = 8'h02,
        OP_WR_VAL = 8'h03,
        OP_NOP    = 8'h04
    } regop_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_DONE
    } regop_state_e;

    localparam int unsigned PRESERVE_BIT = 0;
    localparam logic [7:0]  SPACE_MEM    = 8'h00;
    localparam logic [7:0]  SPACE_IO     = 8'h01;
endpackage

// File: rtl/regop_field.sv
// Field shifter: pulls a masked field out of a register word and builds the
// shifted insert value and the keep mask used by a merging write.
// Assumes OFFW bits are enough to address every bit of a DW-bit word.
module regop_field #(
    parameter int DW   = 64,
    parameter int OFFW = $clog2(DW)
) (
    input  logic [DW-1:0]   rdata,
    input  logic [DW-1:0]   src,
    input  logic [DW-1:0]   mask,
    input  logic [OFFW-1:0] off,
    output logic [DW-1:0]   fld,
    output logic [DW-1:0]   ins,
    output logic [DW-1:0]   keep
);
    // Extract, insert and keep-mask computation.
    always_comb begin
        fld  = (rdata >> off) & mask;
        ins  = (src & mask) << off;
        keep = ~(mask << off);
    end
endmodule

// File: rtl/regop_ctrl.sv
// Sequencer: latches one instruction on start, runs zero, one or two bus
// transfers, and captures the results. Assumes the bus acknowledges each
// request with a single-cycle bus_ack and valid read data in that cycle.
module regop_ctrl
    import regop_pkg::*;
#(
    parameter int DW   = 64,
    parameter int AW   = 32,
    parameter int OFFW = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [7:0]      opcode,
    input  logic [7:0]      flags,
    input  logic [7:0]      addr_space,
    input  logic [AW-1:0]   reg_addr,
    input  logic [OFFW-1:0] bit_off,
    input  logic [DW-1:0]   value,
    input  logic [DW-1:0]   mask,
    input  logic [DW-1:0]   wdata_in,
    input  logic [DW-1:0]   bus_rdata,
    input  logic            bus_ack,
    input  logic [DW-1:0]   fld_x,
    input  logic [DW-1:0]   ins,
    input  logic [DW-1:0]   keep,
    output logic [OFFW-1:0] off_q,
    output logic [DW-1:0]   mask_q,
    output logic [DW-1:0]   src_q,
    output logic            bus_req,
    output logic            bus_we,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   field_out,
    output logic            match,
    output logic            err
);
    regop_state_e  state;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] val_q;
    logic [DW-1:0] merge_q;
    logic          wr_q;
    logic          cmp_q;
    logic          pres_q;
    logic [DW-1:0] field_q;
    logic          match_q;
    logic          err_q;

    logic is_rd, is_wr, is_nop, bad;

    // Decode the presented instruction.
    always_comb begin
        is_rd  = (opcode == OP_READ) || (opcode == OP_CHECK);
        is_wr  = (opcode == OP_WR_EXT) || (opcode == OP_WR_VAL);
        is_nop = (opcode == OP_NOP);
        bad    = !(is_rd || is_wr || is_nop) ||
                 !((addr_space == SPACE_MEM) || (addr_space == SPACE_IO));
    end

    // Instruction sequencing and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            off_q   <= '0;
            mask_q  <= '0;
            src_q   <= '0;
            val_q   <= '0;
            merge_q <= '0;
            wr_q    <= 1'b0;
            cmp_q   <= 1'b0;
            pres_q  <= 1'b0;
            field_q <= '0;
            match_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    addr_q <= reg_addr;
                    off_q  <= bit_off;
                    mask_q <= mask;
                    val_q  <= value;
                    src_q  <= (opcode == OP_WR_VAL) ? value : wdata_in;
                    wr_q   <= is_wr;
                    cmp_q  <= (opcode == OP_CHECK);
                    pres_q <= is_wr && flags[PRESERVE_BIT];
                    if (bad || is_nop) begin
                        err_q   <= bad;
                        field_q <= '0;
                        match_q <= 1'b0;
                        state   <= ST_DONE;
                    end else if (is_wr && !flags[PRESERVE_BIT]) begin
                        state <= ST_WR;
                    end else begin
                        state <= ST_RD;
                    end
                end
                ST_RD: if (bus_ack) begin
                    if (wr_q) begin
                        merge_q <= (bus_rdata & keep) | ins;
                        state   <= ST_WR;
                    end else begin
                        field_q <= fld_x;
                        match_q <= cmp_q && (fld_x == val_q);
                        err_q   <= 1'b0;
                        state   <= ST_DONE;
                    end
                end
                ST_WR: if (bus_ack) begin
                    field_q <= '0;
                    match_q <= 1'b0;
                    err_q   <= 1'b0;
                    state   <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus and status outputs from state.
    always_comb begin
        bus_req   = (state == ST_RD) || (state == ST_WR);
        bus_we    = (state == ST_WR);
        bus_addr  = addr_q;
        bus_wdata = pres_q ? merge_q : ins;
        busy      = bus_req;
        done      = (state == ST_DONE);
        field_out = field_q;
        match     = match_q;
        err       = err_q;
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                    $stable(bus_we) && $stable(bus_wdata)));

    p_ack_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_ack) |=> done);

    p_result_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !start) |=> ($stable(field_out) && $stable(match) &&
                                        $stable(err)));

    p_bad_no_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && start && bad) |=> (!bus_req && done && err));
endmodule

// File: rtl/regop_engine.sv
// Top of the register field access engine: joins the sequencer with the
// field shifter. Assumes a single outstanding bus transfer at a time.
module regop_engine #(
    parameter int DW   = 64,
    parameter int AW   = 32,
    parameter int OFFW = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [7:0]      opcode,
    input  logic [7:0]      flags,
    input  logic [7:0]      addr_space,
    input  logic [AW-1:0]   reg_addr,
    input  logic [OFFW-1:0] bit_off,
    input  logic [DW-1:0]   value,
    input  logic [DW-1:0]   mask,
    input  logic [DW-1:0]   wdata_in,
    output logic            bus_req,
    output logic            bus_we,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    input  logic            bus_ack,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   field_out,
    output logic            match,
    output logic            err
);
    logic [OFFW-1:0] off_q;
    logic [DW-1:0]   mask_q;
    logic [DW-1:0]   src_q;
    logic [DW-1:0]   fld_x;
    logic [DW-1:0]   ins;
    logic [DW-1:0]   keep;

    regop_field #(.DW(DW), .OFFW(OFFW)) u_field (
        .rdata (bus_rdata),
        .src   (src_q),
        .mask  (mask_q),
        .off   (off_q),
        .fld   (fld_x),
        .ins   (ins),
        .keep  (keep)
    );

    regop_ctrl #(.DW(DW), .AW(AW), .OFFW(OFFW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .opcode     (opcode),
        .flags      (flags),
        .addr_space (addr_space),
        .reg_addr   (reg_addr),
        .bit_off    (bit_off),
        .value      (value),
        .mask       (mask),
        .wdata_in   (wdata_in),
        .bus_rdata  (bus_rdata),
        .bus_ack    (bus_ack),
        .fld_x      (fld_x),
        .ins        (ins),
        .keep       (keep),
        .off_q      (off_q),
        .mask_q     (mask_q),
        .src_q      (src_q),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .busy       (busy),
        .done       (done),
        .field_out  (field_out),
        .match      (match),
        .err        (err)
    );

    p_field_in_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> ((field_out & ~mask_q) == '0));
endmodule

// File: tb/tb_regop_engine.sv
module tb_regop_engine;
    localparam int DW = 64;
    localparam int AW = 32;
    localparam int OFFW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] opcode = '0, flags = '0, addr_space = '0;
    logic [AW-1:0] reg_addr = '0;
    logic [OFFW-1:0] bit_off = '0;
    logic [DW-1:0] value = '0, mask = '0, wdata_in = '0;
    logic bus_req, bus_we, bus_ack, busy, done, match, err;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata, field_out;

    int checks = 0;
    int fails = 0;
    int lat = 0;
    int nrd = 0;
    int nwr = 0;
    int cnt = 0;
    logic [DW-1:0] mem [16];

    always #4 clk = ~clk;

    regop_engine #(.DW(DW), .AW(AW), .OFFW(OFFW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .flags(flags), .addr_space(addr_space), .reg_addr(reg_addr),
        .bit_off(bit_off), .value(value), .mask(mask), .wdata_in(wdata_in),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .busy(busy), .done(done), .field_out(field_out), .match(match),
        .err(err)
    );

    assign bus_rdata = mem[bus_addr[3:0]];

    // Register responder with programmable latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0;
            cnt <= 0;
            for (int i = 0; i < 16; i++)
                mem[i] <= 64'h9E37_79B9_7F4A_7C15 * 64'(i + 3);
        end else begin
            if (bus_req && bus_ack) begin
                if (bus_we) begin
                    mem[bus_addr[3:0]] <= bus_wdata;
                    nwr <= nwr + 1;
                end else begin
                    nrd <= nrd + 1;
                end
            end
            if (bus_req && !bus_ack) begin
                if (cnt >= lat) begin
                    bus_ack <= 1'b1;
                    cnt <= 0;
                end else begin
                    cnt <= cnt + 1;
                end
            end else begin
                bus_ack <= 1'b0;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Run one instruction and check it against the bench's own arithmetic.
    task automatic run_op(input logic [7:0] op, input logic [7:0] fl,
                          input logic [7:0] sp, input logic [3:0] a,
                          input logic [OFFW-1:0] off, input logic [DW-1:0] val,
                          input logic [DW-1:0] msk, input logic [DW-1:0] ws);
        logic [DW-1:0] old, f, src, newr, expr;
        int r0, w0, erd, ewr, waitc;
        logic bad, isw, pres;
        string tag;
        old = mem[a];
        r0 = nrd;
        w0 = nwr;
        bad = (op > 8'h04) || (sp > 8'h01);
        isw = (op == 8'h02) || (op == 8'h03);
        pres = fl[0];
        f = (old >> off) & msk;
        src = (op == 8'h03) ? val : ws;
        newr = pres ? ((old & ~(msk << off)) | ((src & msk) << off))
                    : ((src & msk) << off);
        @(negedge clk);
        opcode = op; flags = fl; addr_space = sp; reg_addr = {28'h0, a};
        bit_off = off; value = val; mask = msk; wdata_in = ws; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        opcode = 8'hEE; value = ~val; mask = ~msk; wdata_in = ~ws;
        if (bad || op == 8'h04) begin
            tag = bad ? "R9" : "R8";
            chk(done === 1'b1 && busy === 1'b0, tag, {62'h0, done, busy}, 64'h2);
            chk(err === bad, tag, {63'h0, err}, {63'h0, bad});
            @(negedge clk);
            chk(nrd == r0 && nwr == w0 && mem[a] == old, tag, mem[a], old);
            return;
        end
        chk(busy === 1'b1, "R10", {63'h0, busy}, 64'h1);
        waitc = 0;
        while (done !== 1'b1 && waitc < 20) begin
            @(negedge clk);
            waitc++;
        end
        chk(done === 1'b1 && busy === 1'b0, "R10", {62'h0, done, busy}, 64'h2);
        erd = (isw && !pres) ? 0 : 1;
        ewr = isw ? 1 : 0;
        if (!isw) tag = (op == 8'h01) ? "R3" : "R2";
        else if (pres) tag = "R6";
        else tag = (op == 8'h03) ? "R5" : "R4";
        chk(nrd - r0 == erd && nwr - w0 == ewr, tag,
            64'(nrd - r0) * 16 + 64'(nwr - w0), 64'(erd) * 16 + 64'(ewr));
        chk(err === 1'b0, tag, {63'h0, err}, 64'h0);
        if (isw) begin
            expr = newr;
            chk(mem[a] == expr, (msk == 64'h1B) ? "R7" : tag, mem[a], expr);
            chk(field_out == 0 && match === 1'b0, "R4", field_out, 64'h0);
        end else begin
            chk(field_out == f, (msk == 64'h1B) ? "R7" : tag, field_out, f);
            chk(match === ((op == 8'h01) && (f == val)), "R3", {63'h0, match},
                {63'h0, (op == 8'h01) && (f == val)});
            chk(mem[a] == old, "R2", mem[a], old);
        end
        @(negedge clk);
        chk(done === 1'b0, "R10", {63'h0, done}, 64'h0);
        @(negedge clk);
        chk(field_out == (isw ? 64'h0 : f), "R10", field_out, isw ? 64'h0 : f);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] masks [4];
        masks[0] = 64'h1B;
        masks[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        masks[2] = 64'hFF;
        masks[3] = 64'h5;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy === 0 && done === 0 && err === 0 && match === 0 &&
            bus_req === 0 && field_out == 0, "R1",
            {59'h0, busy, done, err, match, bus_req}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int off = 0; off < 64; off++) begin
            for (int op = 0; op < 4; op++) begin
                for (int p = 0; p < 2; p++) begin
                    logic [3:0] a;
                    logic [DW-1:0] m, v, ws, f;
                    a = 4'(off + op);
                    m = masks[(off + op) % 4];
                    lat = (off + p) % 3;
                    f = (mem[a] >> off) & m;
                    v = (op == 1 && p == 0) ? f : (64'hC3A5_0F1E_2D3C_4B5A ^ 64'(off));
                    ws = 64'h5A5A_F00F_1234_8765 + 64'(off * 7 + op);
                    run_op(8'(op), {7'h0, p[0]} | 8'hA0, 8'(p), a, 6'(off), v, m, ws);
                end
            end
        end
        run_op(8'h04, 8'h01, 8'h00, 4'h2, 6'd3, 64'h7, 64'hF, 64'h1);
        run_op(8'h04, 8'h00, 8'h01, 4'h5, 6'd0, 64'h0, 64'hFF, 64'h0);
        run_op(8'h05, 8'h00, 8'h00, 4'h1, 6'd2, 64'h3, 64'h1B, 64'hFF);
        run_op(8'hFF, 8'h01, 8'h01, 4'h3, 6'd8, 64'h3, 64'hFF, 64'hFF);
        run_op(8'h02, 8'h00, 8'h02, 4'h4, 6'd1, 64'h3, 64'hFF, 64'hFF);
        run_op(8'h00, 8'h00, 8'hFF, 4'h6, 6'd0, 64'h0, 64'hFF, 64'h0);
        run_op(8'h01, 8'h01, 8'h00, 4'h7, 6'd60, 64'h0, 64'hF, 64'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule